// File: doc/BRIEF.md
# Pipelined Restoring Array Divider

This block divides an N-bit unsigned dividend by an M-bit unsigned divisor, with N no smaller than M. It delivers an N-bit quotient and an M-bit remainder. The work is spread over N restoring rows, and each row has a register behind it. Because of that, a fresh dividend/divisor pair can enter on every clock edge, and each result leaves N register stages later.

Row i trial-subtracts the divisor from its working value. It does this as the working value plus the inverted divisor plus one, where the "plus one" enters as the carry into the least significant bit. The carry out of the row's top bit is the comparison result. When it is high, the row hands on the difference. When it is low, the row hands on the working value unchanged. That carry is also quotient bit N-1-i.

The first M rows are M bits wide. Every row after them is M+1 bits wide. Each row appends the next lower dividend bit to the partial remainder it receives. The tag input says whether the pair entering this cycle counts as a real request. It feeds only a shift register of depth N. That shift register raises the result-valid flag in step with the matching result. The dividend, divisor and the quotient bits formed so far ride along in registers beside each row, so every pair stays together through the pipe.

There is no state machine. Control is the single valid shift register, which has asynchronous reset.

Top module: `pdiv_array`

## Requirements
- R1: For a nonzero divisor, the outputs satisfy quot = floor(dividend / divisor) and rem = dividend mod divisor, so dividend = divisor*quot + rem and rem < divisor.
- R2: Operands and the tag are sampled on a rising edge t. The result is on `quot`/`rem`, and `res_ok` is 1, from rising edge t+N-1 until rising edge t+N. A single tagged pair gives a `res_ok` pulse exactly one cycle long.
- R3: A new operand pair may be presented on every cycle. Back-to-back pairs produce their own results on consecutive cycles, in the order they entered.
- R4: The tag input affects only `res_ok`. An untagged pair still yields its correct quotient and remainder at the same latency, while `res_ok` stays 0.
- R5: A zero divisor produces quot = all ones (2^N - 1) and rem = the low M bits of the dividend.
- R6: While `rst_n` is low, `res_ok` is 0. This takes effect at once, without waiting for a clock edge, and discards any tagged results still in flight.
- R7: The extreme operands give exact results: dividend = 2^N-1 with divisor 1, dividend 0, dividend smaller than the divisor, and the largest divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the valid shift register |
| tag_in | input | 1 | Marks the operand pair presented this cycle as a request |
| dividend | input | N | Unsigned dividend |
| divisor | input | M | Unsigned divisor |
| quot | output | N | Quotient, N cycles after entry |
| rem | output | M | Remainder, N cycles after entry |
| res_ok | output | 1 | High when quot/rem belong to a tagged pair |

## Verification
Several patterns are sent one at a time. These include a classic example with a quotient bit of 1 in both the narrow and the wide rows, pairs that produce borrows in the upper rows, and a divisor larger than the dividend. Together they separate a correct carry-out quotient from a swapped or inverted select.

A stream of twelve different back-to-back pairs shows whether the dividend bits, divisor and quotient bits stay aligned stage to stage. A misaligned delay register mixes neighbouring pairs, and the stream exposes that.

Further checks cover:
- a zero divisor and the extreme operands, which exercise the wrap of the carry chain;
- an untagged pair, which separates the data path from the valid path;
- a reset pulse in mid-flight, which shows that the flag clears asynchronously.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Width of restoring row i: the first m rows need m bits, the rest m+1.
    function automatic int row_width(input int i, input int m);
        return (i < m) ? m : m + 1;
    endfunction

endpackage

// File: rtl/pdiv_row.sv
module pdiv_row #(
    parameter int W = 5,
    parameter int M = 4
) (
    input  logic [W-1:0] work,
    input  logic [M-1:0] dvs,
    input  logic         live,
    output logic         ge,
    output logic [M-1:0] part
);
    logic [W-1:0] dvs_inv;
    logic [W:0]   sum;

    // minuend + not(divisor) + carry-in of one
    assign dvs_inv = ~W'(dvs);
    assign sum     = {1'b0, work} + {1'b0, dvs_inv} + (W+1)'(1);
    assign ge      = sum[W];
    assign part    = ge ? sum[M-1:0] : work[M-1:0];

    always_comb begin
        if (live) begin
            // R1: the carry out of the chain must equal a plain comparison
            p_carry_is_compare_r1: assert (ge == (work >= W'(dvs)));
        end
    end

    if (W > M) begin : g_wide
        always_comb begin
            if (live && (dvs != '0) && ge) begin
                // R1: a wide-row difference always fits in M bits
                p_diff_fits_r1: assert (sum[W-1:M] == '0);
            end
        end
    end
endmodule

// File: rtl/pdiv_valid_sr.sv
module pdiv_valid_sr #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_in,
    output logic [DEPTH-1:0] stage_ok
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_ok <= '0;
        end else begin
            stage_ok <= {stage_ok[DEPTH-2:0], tag_in};
        end
    end

    // R2: every flag moves exactly one position per cycle
    p_flag_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tag_in |=> stage_ok[0]);
endmodule

// File: rtl/pdiv_array.sv
module pdiv_array #(
    parameter int N = 8,
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tag_in,
    input  logic [N-1:0] dividend,
    input  logic [M-1:0] divisor,
    output logic [N-1:0] quot,
    output logic [M-1:0] rem,
    output logic         res_ok
);
    localparam int XW = N + M;

    logic [N-1:0] stage_ok;

    pdiv_valid_sr #(.DEPTH(N)) u_vsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_in   (tag_in),
        .stage_ok (stage_ok)
    );

    for (genvar i = 0; i < N; i++) begin : stg
        localparam int W = pdiv_pkg::row_width(i, M);

        logic [W-1:0] work;
        logic         ge;
        logic         live;
        logic [M-1:0] part;
        logic [N-1:0] a_src;
        logic [M-1:0] b_src;
        logic [N-1:0] q_src;

        logic [N-1:0] a_q;
        logic [M-1:0] b_q;
        logic [M-1:0] r_q;
        logic [N-1:0] q_q;

        if (i == 0) begin : g_head
            assign a_src = dividend;
            assign b_src = divisor;
            assign q_src = '0;
            assign live  = tag_in;
            assign work  = W'(dividend[N-1]);
        end else begin : g_body
            assign a_src = stg[i-1].a_q;
            assign b_src = stg[i-1].b_q;
            assign q_src = stg[i-1].q_q;
            assign live  = stage_ok[i-1];
            assign work  = {stg[i-1].r_q[W-2:0], stg[i-1].a_q[N-1-i]};
        end

        pdiv_row #(.W(W), .M(M)) u_row (
            .work (work),
            .dvs  (b_src),
            .live (live),
            .ge   (ge),
            .part (part)
        );

        always_ff @(posedge clk) begin
            a_q <= a_src;
            b_q <= b_src;
            r_q <= part;
            q_q <= {q_src[N-2:0], ge};
        end
    end

    assign quot   = stg[N-1].q_q;
    assign rem    = stg[N-1].r_q;
    assign res_ok = stage_ok[N-1];

    // R1: the quotient and remainder rebuild the dividend
    p_identity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ok && stg[N-1].b_q != '0) |->
        (XW'(quot) * XW'(stg[N-1].b_q) + XW'(rem) == XW'(stg[N-1].a_q)));

    // R1: the remainder stays below the divisor
    p_rem_below_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ok && stg[N-1].b_q != '0) |-> (rem < stg[N-1].b_q));

    // R5: a zero divisor gives all ones and the dividend's low bits
    p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ok && stg[N-1].b_q == '0) |->
        (quot == '1 && rem == stg[N-1].a_q[M-1:0]));

    // R6: reset holds the valid flag low
    p_reset_quiet_r6: assert property (@(posedge clk)
        !rst_n |-> !res_ok);
endmodule

// File: tb/sim_pdiv_array.sv
`timescale 1ns/1ps
module sim_pdiv_array;
    localparam int NB = 8;
    localparam int MB = 4;
    localparam int K  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tag_in = 1'b0;
    logic [NB-1:0] dividend = '0;
    logic [MB-1:0] divisor = '0;
    logic [NB-1:0] quot;
    logic [MB-1:0] rem;
    logic          res_ok;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pdiv_array #(.N(NB), .M(MB)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_in   (tag_in),
        .dividend (dividend),
        .divisor  (divisor),
        .quot     (quot),
        .rem      (rem),
        .res_ok   (res_ok)
    );

    task automatic check(input string req, input string what,
                         input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int exp_q(input int a, input int b);
        return (b == 0) ? (1 << NB) - 1 : a / b;
    endfunction

    function automatic int exp_r(input int a, input int b);
        return (b == 0) ? (a % (1 << MB)) : a % b;
    endfunction

    // one pair through an empty pipe; sampled N negedges after driving
    task automatic run_one(input string req, input int a, input int b,
                           input logic tg);
        @(negedge clk);
        dividend = NB'(a);
        divisor  = MB'(b);
        tag_in   = tg;
        @(negedge clk);
        dividend = '0;
        divisor  = '0;
        tag_in   = 1'b0;
        repeat (NB-1) @(negedge clk);
        check(req, "quotient", quot, exp_q(a, b));
        check(req, "remainder", rem, exp_r(a, b));
        check(req, "valid flag", res_ok, tg);
        @(negedge clk);
        check("R2", "valid pulse width", res_ok, 0);
    endtask

    task automatic t_reset_state;
        repeat (3) @(negedge clk);
        check("R6", "valid during reset", res_ok, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "valid after release", res_ok, 0);
    endtask

    task automatic t_singles;
        run_one("R1", 140, 9, 1'b1);
        run_one("R1", 200, 7, 1'b1);
        run_one("R2", 99, 10, 1'b1);
        run_one("R1", 171, 13, 1'b1);
    endtask

    task automatic t_stream;
        int av [K];
        int bv [K];
        for (int k = 0; k < K; k++) begin
            av[k] = (k * 37 + 11) % 256;
            bv[k] = (k % 15) + 1;
        end
        for (int k = 0; k < K + NB; k++) begin
            @(negedge clk);
            if (k >= NB) begin
                check("R3", "stream quotient", quot, exp_q(av[k-NB], bv[k-NB]));
                check("R3", "stream remainder", rem, exp_r(av[k-NB], bv[k-NB]));
                check("R3", "stream valid", res_ok, 1);
            end
            if (k < K) begin
                dividend = NB'(av[k]);
                divisor  = MB'(bv[k]);
                tag_in   = 1'b1;
            end else begin
                dividend = '0;
                divisor  = '0;
                tag_in   = 1'b0;
            end
        end
        @(negedge clk);
        check("R3", "stream drained", res_ok, 0);
    endtask

    task automatic t_untagged;
        run_one("R4", 223, 6, 1'b0);
    endtask

    task automatic t_zero_div;
        run_one("R5", 167, 0, 1'b1);
        run_one("R5", 0, 0, 1'b1);
    endtask

    task automatic t_bounds;
        run_one("R7", 255, 1, 1'b1);
        run_one("R7", 0, 9, 1'b1);
        run_one("R7", 6, 9, 1'b1);
        run_one("R7", 255, 15, 1'b1);
        run_one("R7", 14, 15, 1'b1);
    endtask

    task automatic t_async_reset;
        @(negedge clk);
        dividend = 8'd50;
        divisor  = 4'd5;
        tag_in   = 1'b1;
        repeat (NB) @(negedge clk);
        check("R2", "valid before reset", res_ok, 1);
        #2;
        rst_n = 1'b0;
        #1;
        check("R6", "valid cleared without edge", res_ok, 0);
        @(negedge clk);
        tag_in = 1'b0;
        rst_n  = 1'b1;
        repeat (NB) @(negedge clk);
        check("R6", "flushed flags stay low", res_ok, 0);
    endtask

    initial begin
        t_reset_state();
        t_singles();
        t_stream();
        t_untagged();
        t_zero_div();
        t_bounds();
        t_async_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule